// File: doc/BRIEF.md
# Channel-Partitioned Audio Sample FIFO

This block buffers audio samples for one direction of a serial audio port. A parameter fixes it as a playback FIFO or a capture FIFO. In playback, software writes 24-bit words into the data port and the line side takes one word on each strobe. In capture, the line side delivers one word on each strobe and software reads it from the data port. A 16-bit sample travels left-justified in the word, in bits 23:8. The bit-clock and frame formatter on the line side are not part of this block. A one-cycle sample strobe stands in for them.

The storage holds 256 words. It is shared among the channels of an interleaved stream, so the number of words a channel may use shrinks as more channels become active. The fill level is reported in frames: the number of stored words divided by the channel count, rounded down. Two sticky flags record a dropped write to a full FIFO and a dropped read from an empty one. Software can empty the FIFO with one write. A level-sensitive service request is raised relative to half of the usable storage. Playback asks to be refilled. Capture asks to be drained.

Top module: `audio_chan_fifo`

## Requirements
- R1: The format register (address 0x0) holds a mode code in bits 6:4 and a channel field in bits 3:0, and reads both back, with all other bits reading as zero. Modes 0 and 1 use one channel. Modes 2 and 3 use two. Modes 4 and 5 use the channel field plus one, and a result above eight counts as eight. Modes 6 and 7 count as one channel.
- R2: The usable words per channel are 256 for one channel, 128 for two, 64 for three or four, and 32 for five to eight. The FIFO is full when the stored words reach that figure times the channel count.
- R3: Words leave in the order they entered. Only bits 23:0 are stored. Bits 31:24 of a write are ignored, and bits 31:24 of a read return zero.
- R4: Status register (address 0x8) bits 16:8 report the stored words divided by the channel count, rounded down.
- R5: A write into a full FIFO is dropped, and it sets the overflow flag in status bit 4.
- R6: A read from an empty FIFO is dropped, sets the underflow flag in status bit 0, and returns zero data.
- R7: Each flag stays set until software writes the status register with that flag's bit at 0. Writing a 1 to that bit leaves the flag unchanged.
- R8: Writing control (address 0x4) with bit 0 set empties the FIFO. Control bit 0 always reads as 0, and the flags are not changed by this clear.
- R9: The service request is active only while control bit 20 is set. Playback raises it when the stored words are at or below half the full level. Capture raises it when they are at or above half the full level.
- R10: In playback, a software write to the data port (address 0xC) adds a word, a line strobe removes the head word, and the head word is shown on ln_rdata. In capture, a line strobe adds ln_wdata, and a software read of the data port returns the head word and removes it.
- R11: Registers are selected by address bits 3:2. Address bits 1:0 are ignored.
- R12: After reset the FIFO is empty, both flags are clear, format and control read as zero, and the service request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data port in capture) |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| ln_strobe | input | 1 | Line-side sample strobe |
| ln_wdata | input | 24 | Line-side sample to store (capture) |
| ln_rdata | output | 24 | Head sample for the line side (playback), zero when empty |
| svc_irq | output | 1 | Service request at the half level |

## Verification
A wrong pointer or count shows up at the ports within one access. It appears as an out-of-order word on the scoreboard at the next strobe or data read, or as a wrong residue in the next status read. A wrong channel decode shows up in the residue quotient and in the word on which overflow is first flagged. For that reason the bench fills each tested channel count up to its exact limit and one word beyond it. A flag that clears itself or fails to set is caught by the status read that follows the event. A wrong threshold is caught by sampling the service request exactly at the half point.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int WORD_W       = 24;
  localparam int CTL_CLR_BIT  = 0;
  localparam int CTL_HALF_BIT = 20;
  localparam int STS_OVF_BIT  = 4;
  localparam int STS_UNF_BIT  = 0;
  localparam int STS_RES_LSB  = 8;
  localparam int MAX_CHANS    = 8;

  typedef enum logic [1:0] {
    SEL_FMT = 2'd0,
    SEL_CTL = 2'd1,
    SEL_STS = 2'd2,
    SEL_DAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/asf_cfg_decode.sv
module asf_cfg_decode #(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [2:0]       mode,
  input  logic [3:0]       ch_field,
  output logic [3:0]       chans,
  output logic [CNT_W-1:0] cap_words,
  output logic [CNT_W-1:0] half_words
);
  logic [4:0]       tdm_count;
  logic [CNT_W-1:0] per_chan;

  always_comb begin
    tdm_count = {1'b0, ch_field} + 5'd1;
    case (mode)
      3'd2, 3'd3: chans = 4'd2;
      3'd4, 3'd5: chans = (tdm_count > 5'(asf_pkg::MAX_CHANS)) ? 4'(asf_pkg::MAX_CHANS)
                                                               : tdm_count[3:0];
      default:    chans = 4'd1;
    endcase
  end

  always_comb begin
    if (chans == 4'd1)      per_chan = CNT_W'(DEPTH);
    else if (chans == 4'd2) per_chan = CNT_W'(DEPTH / 2);
    else if (chans <= 4'd4) per_chan = CNT_W'(DEPTH / 4);
    else                    per_chan = CNT_W'(DEPTH / 8);
  end

  assign cap_words  = CNT_W'(per_chan * CNT_W'(chans));
  assign half_words = cap_words >> 1;
endmodule

// File: rtl/asf_store.sv
module asf_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 24,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  input  logic [CNT_W-1:0] cap_words,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count_q,
  output logic             push_drop,
  output logic             pop_drop
);
  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             full, empty, wr_ok, rd_ok, state_en;

  assign full  = (count_q >= cap_words);
  assign empty = (count_q == '0);

  always_comb begin
    wr_ok     = push & ~full & ~clr;
    rd_ok     = pop & ~empty & ~clr;
    push_drop = push & full & ~clr;
    pop_drop  = pop & empty & ~clr;
    state_en  = clr | wr_ok | rd_ok;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      wr_ptr_d = wr_ptr_q + AW'(wr_ok);
      rd_ptr_d = rd_ptr_q + AW'(rd_ok);
      count_d  = count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (state_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= push_data;
  end

  assign head = empty ? '0 : mem[rd_ptr_q];

  // R8: a clear leaves the FIFO empty on the next cycle
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));
  // R5: a dropped write does not grow the fill
  a_r5_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count_q == $past(count_q)));
  // R6: a dropped read on empty keeps it empty unless something arrives
  a_r6_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count_q == '0));
  // R2: fill never exceeds the storage
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/asf_sticky.sv
module asf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic drop_req,
  output logic flag_q
);
  logic flag_d;

  always_comb flag_d = set_evt | (flag_q & ~drop_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (set_evt | drop_req) flag_q <= flag_d;
  end

  // R7: a set flag survives every cycle without a clear request
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !drop_req) |=> flag_q);
  // R5 and R6: an error event always leaves the flag set
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
endmodule

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo #(
  parameter bit IS_CAPTURE = 1'b0,
  parameter int DEPTH      = 256,
  localparam int DW    = asf_pkg::WORD_W,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ln_strobe,
  input  logic [DW-1:0] ln_wdata,
  output logic [DW-1:0] ln_rdata,
  output logic          svc_irq
);
  import asf_pkg::*;

  reg_sel_e         sel;
  logic [2:0]       mode_q, mode_d;
  logic [3:0]       chf_q, chf_d;
  logic             half_en_q, half_en_d;
  logic             fmt_we, ctl_we, sts_we, clr;
  logic [3:0]       chans;
  logic [CNT_W-1:0] cap_words, half_words, count;
  logic [CNT_W-1:0] residue;
  logic             push, pop, push_drop, pop_drop;
  logic [DW-1:0]    push_data, head, dat_rd;
  logic [1:0]       flag_q;
  logic             unused_bits;

  assign sel    = reg_sel_e'(reg_addr[3:2]);
  assign fmt_we = reg_wr && (sel == SEL_FMT);
  assign ctl_we = reg_wr && (sel == SEL_CTL);
  assign sts_we = reg_wr && (sel == SEL_STS);
  assign clr    = ctl_we && reg_wdata[CTL_CLR_BIT];

  assign unused_bits = ^{reg_wdata[31:DW], reg_addr[1:0], ln_wdata, reg_rd};

  always_comb begin
    mode_d    = fmt_we ? reg_wdata[6:4] : mode_q;
    chf_d     = fmt_we ? reg_wdata[3:0] : chf_q;
    half_en_d = ctl_we ? reg_wdata[CTL_HALF_BIT] : half_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      chf_q  <= '0;
    end else if (fmt_we) begin
      mode_q <= mode_d;
      chf_q  <= chf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_en_q <= 1'b0;
    else if (ctl_we) half_en_q <= half_en_d;
  end

  asf_cfg_decode #(.DEPTH(DEPTH)) u_cfg (
    .mode       (mode_q),
    .ch_field   (chf_q),
    .chans      (chans),
    .cap_words  (cap_words),
    .half_words (half_words)
  );

  generate
    if (IS_CAPTURE) begin : g_capture
      assign push      = ln_strobe;
      assign push_data = ln_wdata;
      assign pop       = reg_rd && (sel == SEL_DAT);
      assign ln_rdata  = '0;
      assign dat_rd    = head;
      assign svc_irq   = half_en_q && (count >= half_words);
    end else begin : g_playback
      assign push      = reg_wr && (sel == SEL_DAT);
      assign push_data = reg_wdata[DW-1:0];
      assign pop       = ln_strobe;
      assign ln_rdata  = head;
      assign dat_rd    = '0;
      assign svc_irq   = half_en_q && (count <= half_words);
    end
  endgenerate

  asf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .cap_words (cap_words),
    .head      (head),
    .count_q   (count),
    .push_drop (push_drop),
    .pop_drop  (pop_drop)
  );

  // flag 0: overflow (status bit 4), flag 1: underflow (status bit 0)
  generate
    for (genvar g = 0; g < 2; g++) begin : g_flag
      localparam int BITPOS = (g == 0) ? STS_OVF_BIT : STS_UNF_BIT;
      asf_sticky u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  ((g == 0) ? push_drop : pop_drop),
        .drop_req (sts_we && !reg_wdata[BITPOS]),
        .flag_q   (flag_q[g])
      );
    end
  endgenerate

  assign residue = count / CNT_W'(chans);

  always_comb begin
    case (sel)
      SEL_FMT: reg_rdata = {25'b0, mode_q, chf_q};
      SEL_CTL: reg_rdata = 32'(half_en_q) << CTL_HALF_BIT;
      SEL_STS: reg_rdata = (32'(residue) << STS_RES_LSB)
                         | (32'(flag_q[0]) << STS_OVF_BIT)
                         | (32'(flag_q[1]) << STS_UNF_BIT);
      default: reg_rdata = 32'(dat_rd);
    endcase
  end

  // R9: the request is never raised while the half-level source is off
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !reg_wdata[CTL_HALF_BIT]) |=> !svc_irq);
  // R4: the reported residue never exceeds the per-channel depth
  a_r4_residue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    residue <= CNT_W'(DEPTH));
endmodule

// File: tb/test_audio_chan_fifo.sv
`timescale 1ns/1ps
module test_audio_chan_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        pb_wr = 0, pb_rd = 0, pb_strobe = 0;
  logic [3:0]  pb_addr = 0;
  logic [31:0] pb_wdata = 0, pb_rdata;
  logic [23:0] pb_lnw = 0, pb_lnr;
  logic        pb_irq;

  logic        cp_wr = 0, cp_rd = 0, cp_strobe = 0;
  logic [3:0]  cp_addr = 0;
  logic [31:0] cp_wdata = 0, cp_rdata;
  logic [23:0] cp_lnw = 0, cp_lnr;
  logic        cp_irq;

  audio_chan_fifo #(.IS_CAPTURE(1'b0)) i_audio_chan_fifo (
    .clk(clk), .rst_n(rst_n), .reg_wr(pb_wr), .reg_rd(pb_rd), .reg_addr(pb_addr),
    .reg_wdata(pb_wdata), .reg_rdata(pb_rdata), .ln_strobe(pb_strobe),
    .ln_wdata(pb_lnw), .ln_rdata(pb_lnr), .svc_irq(pb_irq));

  audio_chan_fifo #(.IS_CAPTURE(1'b1)) i_audio_chan_fifo_cap (
    .clk(clk), .rst_n(rst_n), .reg_wr(cp_wr), .reg_rd(cp_rd), .reg_addr(cp_addr),
    .reg_wdata(cp_wdata), .reg_rdata(cp_rdata), .ln_strobe(cp_strobe),
    .ln_wdata(cp_lnw), .ln_rdata(cp_lnr), .svc_irq(cp_irq));

  int n_vec = 0, n_bad = 0;
  logic [23:0] pb_q[$];
  logic [23:0] cp_q[$];
  int pb_cap = 256, cp_cap = 256;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int cap_of(logic [31:0] f);
    int mode = int'(f[6:4]);
    int ch;
    int per;
    if (mode <= 1) ch = 1;
    else if (mode <= 3) ch = 2;
    else if (mode <= 5) ch = (int'(f[3:0]) + 1 > 8) ? 8 : int'(f[3:0]) + 1;
    else ch = 1;
    per = (ch == 1) ? 256 : (ch == 2) ? 128 : (ch <= 4) ? 64 : 32;
    return per * ch;
  endfunction

  task automatic bus_wr(bit cap, logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    if (cap) begin cp_wr = 1; cp_addr = a; cp_wdata = d; end
    else     begin pb_wr = 1; pb_addr = a; pb_wdata = d; end
    @(posedge clk); #1;
    cp_wr = 0; pb_wr = 0;
  endtask

  task automatic bus_rd(bit cap, logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    if (cap) begin cp_rd = 1; cp_addr = a; end
    else     begin pb_rd = 1; pb_addr = a; end
    #1 d = cap ? cp_rdata : pb_rdata;
    @(posedge clk); #1;
    cp_rd = 0; pb_rd = 0;
  endtask

  task automatic chk_reg(bit cap, logic [3:0] a, logic [31:0] exp, string tag);
    logic [31:0] v;
    bus_rd(cap, a, v);
    check(tag, v, exp);
  endtask

  task automatic set_fmt(bit cap, logic [31:0] f);
    bus_wr(cap, 4'h0, f);
    if (cap) cp_cap = cap_of(f); else pb_cap = cap_of(f);
  endtask

  task automatic clear(bit cap, bit half);
    bus_wr(cap, 4'h4, (32'(half) << 20) | 32'h1);
    if (cap) cp_q.delete(); else pb_q.delete();
  endtask

  // scoreboard driver: playback data-port write
  task automatic pb_push(logic [31:0] w);
    bus_wr(0, 4'hC, w);
    if (pb_q.size() < pb_cap) pb_q.push_back(w[23:0]);
  endtask

  task automatic pb_drain(int n);
    @(posedge clk); #1 pb_strobe = 1;
    repeat (n) @(posedge clk);
    #1 pb_strobe = 0;
  endtask

  // scoreboard monitor: playback line side
  always @(negedge clk) begin
    if (pb_strobe && rst_n) begin
      if (pb_q.size() > 0) check("R3/R10 playback order", 32'(pb_lnr), 32'(pb_q.pop_front()));
      else                 check("R6 empty head zero", 32'(pb_lnr), 32'h0);
    end
  end

  // scoreboard driver: capture line strobe
  task automatic cp_push(logic [23:0] w);
    @(posedge clk); #1 cp_strobe = 1; cp_lnw = w;
    @(posedge clk); #1 cp_strobe = 0;
    if (cp_q.size() < cp_cap) cp_q.push_back(w);
  endtask

  // scoreboard monitor side for capture: data-port read
  task automatic cp_pop_chk();
    logic [31:0] v;
    bus_rd(1, 4'hC, v);
    if (cp_q.size() > 0) check("R3/R10 capture order", v, 32'(cp_q.pop_front()));
    else                 check("R6 capture empty read", v, 32'h0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12 reset state
    chk_reg(0, 4'h8, 32'h0, "R12 status");
    chk_reg(0, 4'h0, 32'h0, "R12 format");
    chk_reg(0, 4'h4, 32'h0, "R12 control");
    check("R12 irq", 32'(pb_irq), 0);
    check("R12 head", 32'(pb_lnr), 0);
    check("R12 capture irq", 32'(cp_irq), 0);

    // playback basics
    bus_wr(0, 4'h4, 32'h0010_0000);
    chk_reg(0, 4'h4, 32'h0010_0000, "R9 control readback");
    check("R9 playback irq empty", 32'(pb_irq), 1);
    pb_push(32'hAB12_3456);
    pb_push(32'h0065_4321);
    pb_push(32'hFF00_00AA);
    chk_reg(0, 4'h8, 32'h0000_0300, "R4 residue mono");
    chk_reg(0, 4'hB, 32'h0000_0300, "R11 low address bits ignored");
    pb_drain(3);
    chk_reg(0, 4'h8, 32'h0, "R3 drained");
    pb_drain(1);
    chk_reg(0, 4'h8, 32'h0000_0001, "R6 underflow flag");
    bus_wr(0, 4'h8, 32'h11);
    chk_reg(0, 4'h8, 32'h0000_0001, "R7 write one keeps");
    bus_wr(0, 4'h8, 32'h0);
    chk_reg(0, 4'h8, 32'h0, "R7 write zero clears");

    // two channels
    set_fmt(0, 32'h20);
    chk_reg(0, 4'h0, 32'h20, "R1 format readback");
    for (int i = 0; i < 5; i++) pb_push(32'h100 + i);
    chk_reg(0, 4'h8, 32'h0000_0200, "R4 residue two channels");
    clear(0, 1);
    chk_reg(0, 4'h8, 32'h0, "R8 clear empties");
    chk_reg(0, 4'h4, 32'h0010_0000, "R8 clear bit reads zero");

    // three channels: full at 192 words
    set_fmt(0, 32'h42);
    for (int i = 0; i < 192; i++) pb_push(32'h5000 + i);
    chk_reg(0, 4'h8, 32'h0000_4000, "R2 three channel full residue");
    check("R9 playback irq above half", 32'(pb_irq), 0);
    pb_push(32'hDEAD);
    chk_reg(0, 4'h8, 32'h0000_4010, "R5 overflow flag");
    pb_drain(96);
    chk_reg(0, 4'h8, 32'h0000_2010, "R2 residue after drain");
    check("R9 playback irq at half", 32'(pb_irq), 1);
    clear(0, 1);
    chk_reg(0, 4'h8, 32'h0000_0010, "R8 flags survive clear");
    bus_wr(0, 4'h8, 32'h0);

    // channel field above eight counts as eight
    set_fmt(0, 32'h49);
    for (int i = 0; i < 16; i++) pb_push(32'h7000 + i);
    chk_reg(0, 4'h8, 32'h0000_0200, "R1 saturate to eight");
    clear(0, 1);

    // unsupported mode counts as one channel
    set_fmt(0, 32'h60);
    for (int i = 0; i < 3; i++) pb_push(32'h8000 + i);
    chk_reg(0, 4'h8, 32'h0000_0300, "R1 mode six mono");
    clear(0, 1);
    set_fmt(0, 32'hFFFF_FFFF);
    chk_reg(0, 4'h0, 32'h0000_007F, "R1 format field mask");
    bus_wr(0, 4'h4, 32'h0);
    check("R9 irq off", 32'(pb_irq), 0);

    // capture instance
    bus_wr(1, 4'h4, 32'h0010_0000);
    check("R9 capture irq empty", 32'(cp_irq), 0);
    for (int i = 0; i < 127; i++) cp_push(24'h0A_0000 + 24'(i));
    check("R9 capture irq below half", 32'(cp_irq), 0);
    cp_push(24'h0A_0000 + 24'd127);
    check("R9 capture irq at half", 32'(cp_irq), 1);
    chk_reg(1, 4'h8, 32'h0000_8000, "R4 capture residue");
    cp_pop_chk();
    cp_pop_chk();
    cp_pop_chk();
    chk_reg(1, 4'h8, 32'h0000_7D00, "R10 capture pops");
    check("R9 capture irq after pops", 32'(cp_irq), 0);
    clear(1, 1);
    cp_pop_chk();
    chk_reg(1, 4'h8, 32'h0000_0001, "R6 capture underflow");
    bus_wr(1, 4'h8, 32'h0);
    set_fmt(1, 32'h20);
    for (int i = 0; i < 257; i++) cp_push(24'h30_0000 + 24'(i));
    chk_reg(1, 4'h8, 32'h0000_8010, "R5 capture overflow");
    cp_pop_chk();
    cp_pop_chk();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule